// File: doc/BRIEF.md
# Nine-Bit Framed SPI Command Serializer

This block transmits a single panel command over an SPI master link. A command consists of one 8-bit opcode and zero, one or two 8-bit parameter bytes. Each item travels as a 9-bit word with a one-bit type flag in front of it. The flag is 0 for the opcode and 1 for a parameter. The words are joined, left-aligned and zero-padded into 2, 3 or 4 whole bytes. The result is shifted out MSB first with the clock idling high, so data changes on the falling edge and is sampled on the rising edge.

A host pulses `start_i` for one cycle with the opcode, the parameter count, the parameter bytes and a divider value. The block latches all of these at that edge. It drops chip select for the whole frame and raises it again after the last padded bit. It then holds chip select high for one full SCLK period before it reports `done_o`. A parameter count of 3 is rejected: no line moves, and `done_o` pulses together with `err_o`.

Top module: `spi9_cmd_tx`

## Requirements
- R1: In reset and whenever not busy, cs_n_o=1, sclk_o=1, mosi_o=0, busy_o=0, and done_o and err_o are 0 outside their one-cycle pulse.
- R2: The frame is the opcode word {0,opcode[7:0]}, then {1,param0[7:0]} when the count is at least 1, then {1,param1[7:0]} when the count is 2. These are placed from frame bit 31 downward, and every remaining bit is 0.
- R3: A command with count n produces exactly 8*(n+2) SCLK rising edges (16, 24 or 32) while cs_n_o is low.
- R4: SCLK idles high. mosi_o changes only when SCLK falls and is stable across every rising edge.
- R5: cs_n_o falls exactly once per accepted command and stays low until after the last padded bit. SCLK is low only while cs_n_o is low.
- R6: After the last rising edge and one half period, cs_n_o rises and stays high for 2H cycles while busy_o stays 1. busy_o then falls, and done_o is 1 for exactly that first idle cycle with err_o=0.
- R7: A start with count 3 (binary 11) while idle gives done_o=1 and err_o=1 in the next cycle, with busy_o=0 and cs_n_o=1 throughout.
- R8: A start while busy_o=1 is ignored. Inputs that change after the accepting edge do not alter the frame in flight.
- R9: The SCLK half period H equals div_i sampled at the accepting edge, with 0 treated as 1. Every SCLK low phase lasts H cycles, and busy_o stays high for H*(3+2*bits) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle command strobe |
| opcode_i | input | 8 | Opcode byte |
| nparam_i | input | 2 | Parameter count (0 to 2; 3 is invalid) |
| param0_i | input | 8 | First parameter byte |
| param1_i | input | 8 | Second parameter byte |
| div_i | input | 8 | SCLK half period in clock cycles (0 acts as 1) |
| sclk_o | output | 1 | SPI clock, idle high |
| mosi_o | output | 1 | Serial data, MSB first |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Qualifies done_o: rejected parameter count |

## Verification
With half period H and b bits, busy_o is seen from the first falling clock edge after the accepting edge and lasts H*(3+2*b) cycles. done_o appears in the first sample where busy_o is low. A rejected count shows done_o and err_o in the very first sample after the strobe. The bench samples every output on the falling clock edge after each rising edge. It measures each SCLK low phase, the chip-select gap and the busy span in whole cycles against those formulas. It captures mosi_o at every sampled SCLK rise and compares the bits against a frame rebuilt bit by bit from R2.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

  // Sequencer phases of one framed transfer
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // lines parked, waiting for a strobe
    ST_LEAD = 3'd1,  // chip select low, clock still high
    ST_LOW  = 3'd2,  // clock low, new bit on the data line
    ST_HIGH = 3'd3,  // clock high, receiver samples
    ST_GAP  = 3'd4   // chip select released, recovery time
  } seq_state_e;

endpackage

// File: rtl/spi9_rst_sync.sv
module spi9_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/spi9_frame_pack.sv
module spi9_frame_pack #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 2,
  parameter int CNT_W      = 2,
  parameter int FRAME_W    = (MAX_PARAMS + 2) * DATA_W,
  parameter int BITS_W     = 6
) (
  input  logic [DATA_W-1:0]                 opcode_i,
  input  logic [CNT_W-1:0]                  nparam_i,
  input  logic [MAX_PARAMS-1:0][DATA_W-1:0] params_i,
  output logic [FRAME_W-1:0]                frame_o,
  output logic [BITS_W-1:0]                 nbits_o,
  output logic                              valid_o
);

  localparam int WORD_W = DATA_W + 1;
  localparam int NSLOT  = MAX_PARAMS + 1;

  logic [NSLOT-1:0][WORD_W-1:0] words;

  // Slot 0 is the opcode (flag 0), the others are parameters (flag 1)
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == 0) begin : g_op
      assign words[g] = {1'b0, opcode_i};
    end else begin : g_par
      assign words[g] = {1'b1, params_i[g-1]};
    end
  end

  always_comb begin
    frame_o = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (k <= int'(nparam_i)) begin
        frame_o[FRAME_W-1-k*WORD_W -: WORD_W] = words[k];
      end
    end
  end

  assign valid_o = (int'(nparam_i) <= MAX_PARAMS);
  assign nbits_o = BITS_W'((int'(nparam_i) + 2) * DATA_W);

endmodule

// File: rtl/spi9_half_timer.sv
module spi9_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_eff;
  logic             cken;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign cken    = load_i | en_i;

  always_comb begin
    half_d = half_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      half_d = div_eff;
      cnt_d  = div_eff - DIV_W'(1);
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_d = half_q - DIV_W'(1);
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (cken) begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tick_o = en_i && (cnt_q == '0);

endmodule

// File: rtl/spi9_seq.sv
module spi9_seq
  import spi9_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BITS_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BITS_W-1:0]  nbits_i,
  input  logic               tick_i,
  output logic               load_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_n_o,
  output logic               done_o,
  output logic               err_o
);

  seq_state_e         state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [BITS_W-1:0]  left_q, left_d;
  logic               gap2_q, gap2_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && valid_i;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    left_d  = left_q;
    gap2_d  = gap2_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && valid_i) begin
          state_d = ST_LEAD;
          shreg_d = frame_i;
          left_d  = nbits_i;
        end else if (accept) begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick_i) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (tick_i) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick_i) begin
          shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
          left_d  = left_q - BITS_W'(1);
          if (left_q == BITS_W'(1)) begin
            state_d = ST_GAP;
            gap2_d  = 1'b0;
          end else begin
            state_d = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        if (tick_i) begin
          if (gap2_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            gap2_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      gap2_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      left_q  <= left_d;
      gap2_q  <= gap2_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign sclk_o = (state_q != ST_LOW);
  assign cs_n_o = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign mosi_o = ((state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH))
                  && shreg_q[FRAME_W-1];
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/spi9_cmd_tx.sv
module spi9_cmd_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [1:0]        nparam_i,
  input  logic [DATA_W-1:0] param0_i,
  input  logic [DATA_W-1:0] param1_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int MAX_PARAMS = 2;
  localparam int CNT_W      = 2;
  localparam int FRAME_W    = (MAX_PARAMS + 2) * DATA_W;
  localparam int BITS_W     = $clog2(FRAME_W + 1);

  logic                              rst_int_n;
  logic [MAX_PARAMS-1:0][DATA_W-1:0] params;
  logic [FRAME_W-1:0]                frame;
  logic [BITS_W-1:0]                 nbits;
  logic                              valid;
  logic                              load;
  logic                              tick;

  assign params = {param1_i, param0_i};

  spi9_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  spi9_frame_pack #(
    .DATA_W     (DATA_W),
    .MAX_PARAMS (MAX_PARAMS),
    .CNT_W      (CNT_W),
    .FRAME_W    (FRAME_W),
    .BITS_W     (BITS_W)
  ) u_pack (
    .opcode_i (opcode_i),
    .nparam_i (nparam_i),
    .params_i (params),
    .frame_o  (frame),
    .nbits_o  (nbits),
    .valid_o  (valid)
  );

  spi9_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .en_i   (busy_o),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi9_seq #(
    .FRAME_W (FRAME_W),
    .BITS_W  (BITS_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .valid_i (valid),
    .frame_i (frame),
    .nbits_i (nbits),
    .tick_i  (tick),
    .load_o  (load),
    .busy_o  (busy_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

endmodule

// File: rtl/spi9_cmd_tx_chk.sv
module spi9_cmd_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] nparam_i,
  input logic       sclk_o,
  input logic       mosi_o,
  input logic       cs_n_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && sclk_o && !mosi_o));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(mosi_o));

  // R5
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> busy_o);

  // R6
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && !err_o));

  // R7
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && nparam_i == 2'd3) |=> (done_o && err_o && !busy_o && cs_n_o));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || (done_o && !err_o)));

endmodule

bind spi9_cmd_tx spi9_cmd_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .nparam_i (nparam_i),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .cs_n_o   (cs_n_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/tb_spi9_cmd_tx.sv
module tb_spi9_cmd_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {opcode[33:26], count[25:24], param0[23:16], param1[15:8], div[7:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {8'h29, 2'd0, 8'h00, 8'h00, 8'd1},
    {8'hB8, 2'd2, 8'hFF, 8'hF9, 8'd2},
    {8'hB0, 2'd1, 8'h16, 8'h00, 8'd3},
    {8'h00, 2'd0, 8'h00, 8'h00, 8'd0},
    {8'hFF, 2'd2, 8'h00, 8'h00, 8'd1},
    {8'h3A, 2'd1, 8'h60, 8'h00, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [1:0] nparam_i = '0;
  logic [7:0] param0_i = '0;
  logic [7:0] param1_i = '0;
  logic [7:0] div_i = 8'd1;
  logic       sclk_o, mosi_o, cs_n_o, busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi9_cmd_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .nparam_i(nparam_i), .param0_i(param0_i), .param1_i(param1_i), .div_i(div_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Frame rebuilt bit by bit from R2
  function automatic logic [31:0] exp_frame(input logic [7:0] op, input int n,
                                            input logic [7:0] p0, input logic [7:0] p1);
    logic [31:0] f = '0;
    int pos = 31;
    logic [8:0] w;
    for (int k = 0; k <= n; k++) begin
      w = (k == 0) ? {1'b0, op} : (k == 1) ? {1'b1, p0} : {1'b1, p1};
      for (int b = 8; b >= 0; b--) begin
        f[pos] = w[b];
        pos--;
      end
    end
    return f;
  endfunction

  task automatic run_cmd(input logic [7:0] op, input int n, input logic [7:0] p0,
                         input logic [7:0] p1, input logic [7:0] dv, input int poke);
    int h = (dv == 0) ? 1 : int'(dv);
    int nb = 8 * (n + 2);
    logic [31:0] cap = '0;
    int rises = 0, busy_cyc = 0, low_run = 0, low_bad = 0, gap = 0, cs_falls = 0, r4_bad = 0;
    bit prev_sclk = 1'b1, prev_cs = 1'b1, prev_mosi = 1'b0, got_done = 1'b0, err_seen = 1'b0;
    int idle_bad = 0;
    @(negedge clk);
    opcode_i = op; nparam_i = 2'(n); param0_i = p0; param1_i = p1; div_i = dv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 20000 && !got_done; i++) begin
      if (i > 0) @(negedge clk);
      if (busy_o) busy_cyc++;
      if (prev_cs && !cs_n_o) cs_falls++;
      if (!cs_n_o && !sclk_o) low_run++;
      if (sclk_o && !prev_sclk) begin
        if (low_run != h) low_bad++;
        low_run = 0;
        if (!cs_n_o) begin
          cap = {cap[30:0], mosi_o};
          rises++;
        end
      end
      if (busy_o && cs_n_o) gap++;
      if (prev_sclk && sclk_o && !cs_n_o && !prev_cs && (mosi_o != prev_mosi)) r4_bad++;
      if (done_o) begin
        got_done = 1'b1;
        err_seen = err_o;
      end
      prev_sclk = sclk_o; prev_cs = cs_n_o; prev_mosi = mosi_o;
      if (poke >= 0 && i == poke) begin
        // R8: strobe while busy with different inputs
        start_i = 1'b1; opcode_i = ~op; nparam_i = 2'd2; param0_i = 8'h5A; param1_i = 8'hC3; div_i = 8'd7;
      end
      if (poke >= 0 && i == poke + 1) start_i = 1'b0;
    end
    if (rises > 0 && rises < 32) cap = cap << (32 - rises);
    chk(got_done, "R6", "done pulse seen", longint'(got_done), 1);
    chk(rises == nb, "R3", "sclk rising edges", rises, nb);
    chk(cap == exp_frame(op, n, p0, p1), "R2", "captured frame", cap, exp_frame(op, n, p0, p1));
    chk(busy_cyc == h * (3 + 2 * nb), "R9", "busy cycles", busy_cyc, h * (3 + 2 * nb));
    chk(low_bad == 0, "R9", "sclk low phases not H", low_bad, 0);
    chk(gap == 2 * h, "R6", "cs high gap while busy", gap, 2 * h);
    chk(cs_falls == 1, "R5", "cs falls", cs_falls, 1);
    chk(r4_bad == 0, "R4", "mosi moved while sclk high", r4_bad, 0);
    chk(!err_seen, "R6", "err on good done", longint'(err_seen), 0);
    @(negedge clk);
    chk(!done_o, "R6", "done width", longint'(done_o), 0);
    if (poke >= 0) begin
      for (int j = 0; j < 20; j++) begin
        if (!cs_n_o || busy_o) idle_bad++;
        @(negedge clk);
      end
      chk(idle_bad == 0, "R8", "activity after ignored strobe", idle_bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int bad;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs_n_o && sclk_o && !mosi_o && !busy_o && !done_o && !err_o, "R1", "lines in reset",
        {cs_n_o, sclk_o, mosi_o, busy_o, done_o, err_o}, 6'b110000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o && sclk_o && !busy_o && !done_o, "R1", "lines idle after reset",
        {cs_n_o, sclk_o, busy_o, done_o}, 4'b1100);

    // Table-driven transfers: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      run_cmd(VEC[v][33:26], int'(VEC[v][25:24]), VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], -1);
    end

    // R7: invalid parameter count
    @(negedge clk);
    opcode_i = 8'h11; nparam_i = 2'd3; div_i = 8'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && err_o, "R7", "done+err after count 3", {done_o, err_o}, 2'b11);
    chk(!busy_o && cs_n_o, "R7", "no transfer for count 3", {busy_o, cs_n_o}, 2'b01);
    @(negedge clk);
    chk(!done_o && !err_o, "R7", "error pulse width", {done_o, err_o}, 2'b00);
    bad = 0;
    for (int j = 0; j < 10; j++) begin
      if (!cs_n_o || !sclk_o || busy_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7", "lines moved after count 3", bad, 0);

    // R8: strobe while busy is ignored, frame unchanged
    run_cmd(8'hC7, 2, 8'h33, 8'h43, 8'd2, 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule